// File: doc/BRIEF.md
# Reversible Gate-Pair Rewrite Engine

This block rewrites one pair of neighbouring multi-control NOT gates into an equivalent sequence. Each gate is described by a target bit index and a control mask over `NBITS` bit lines. A gate inverts its target line when every line in its control mask is one. An empty mask makes the gate a plain inversion. A third input, `fresh_aux`, marks the auxiliary lines that no earlier gate in the circuit has targeted. Those lines are still zero when the pair is reached.

On every accepted pair the engine picks the first rewrite rule that applies, in a fixed priority. It then emits zero to three replacement gates, their count, and a rule code. A search or optimisation controller outside the block decides which pair to present. That controller uses the rule code to decide whether the rewrite is worth splicing into the circuit. Inputs are registered when `in_valid` is high. The result is combinational from those registers, so it appears one cycle later.

Rule codes on `out_rule`: 0 = no rule, 1 = cancel, 2 = plain swap, 3 = swap with trailing corrective gate, 4 = swap with leading corrective gate, 5 = control substitution, 6 = delete first gate, 7 = delete second gate. Below, g1 = (t1, C1) is the gate on `a_*` and g2 = (t2, C2) is the gate on `b_*`. Slot k is `sk_tgt`/`sk_ctl`.

Top module: `gate_pair_rewriter`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and low after reset or after a cycle with `in_valid` low.
- R2: If t1 = t2 and C1 = C2, the result is rule 1 with count 0.
- R3: Otherwise, if bit t1 of C2 is 0 and bit t2 of C1 is 0, the result is rule 2 with count 2. Slot 0 holds g2 and slot 1 holds g1.
- R4: Otherwise, if bit t1 of C2 is 0, bit t2 of C1 is 1 and t1 ≠ t2, the result is rule 3 with count 3. Slot 0 holds g2, slot 1 holds g1, and slot 2 holds (t1, (C1 | C2) with bit t2 cleared).
- R5: Otherwise, if bit t1 of C2 is 1 and bit t2 of C1 is 0, the result is rule 4 with count 3. Slot 0 holds (t2, (C1 | C2) with bit t1 cleared), slot 1 holds g2 and slot 2 holds g1.
- R6: Otherwise (each target lies in the other gate's mask), if `fresh_aux` bit t1 is 1 and C1 has exactly one bit set, at position c1, the result is rule 5 with count 2. Slot 0 holds g1 and slot 1 holds (t2, C2 with bit t1 cleared and bit c1 set).
- R7: Otherwise, if C1 & `fresh_aux` is nonzero, the result is rule 6 with count 1 and slot 0 holds g2.
- R8: Otherwise, if C2 & `fresh_aux` with bit t1 cleared is nonzero, the result is rule 7 with count 1 and slot 0 holds g1. Bit t1 is excluded because g1 may write that line.
- R9: If none of the rules above applies, the result is rule 0 with count 2, and slots 0 and 1 hold g1 and g2 unchanged.
- R10: Rules are tried in the order R2, R3, R4, R5, R6, R7, R8, and the first match wins. Every slot at or above the count reads as all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Captures the pair on this edge |
| a_tgt | input | IW | Target index of the first gate |
| a_ctl | input | NBITS | Control mask of the first gate |
| b_tgt | input | IW | Target index of the second gate |
| b_ctl | input | NBITS | Control mask of the second gate |
| fresh_aux | input | NBITS | Lines still untouched (known zero) before the pair |
| out_valid | output | 1 | Result valid |
| out_rule | output | 3 | Rule code applied |
| out_count | output | 2 | Number of replacement gates |
| s0_tgt | output | IW | Slot 0 target |
| s0_ctl | output | NBITS | Slot 0 control mask |
| s1_tgt | output | IW | Slot 1 target |
| s1_ctl | output | NBITS | Slot 1 control mask |
| s2_tgt | output | IW | Slot 2 target |
| s2_ctl | output | NBITS | Slot 2 control mask |

## Verification
The stimulus picks gate pairs that each land on a single branch of the rule chain:

- a repeated gate;
- pairs with disjoint target/control relations;
- pairs where only one target feeds the other gate;
- mutually dependent pairs under several `fresh_aux` masks.

The mutually dependent pairs separate substitution from both deletions and from the no-rule result. One pair qualifies for both substitution and first-gate deletion, which shows that the priority is respected. Another pair has its only fresh line on t1, which shows that the t1 exclusion in second-gate deletion holds. The overlapping-control dual swap and the identical-gate case show that the corrective mask drops only the other gate's target, and that cancellation is chosen before the plain swap.

// File: rtl/gate_pair_rewriter.sv
module gate_pair_rewriter #(
  parameter int NBITS = 8,
  localparam int IW = (NBITS > 1) ? $clog2(NBITS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IW-1:0]    a_tgt,
  input  logic [NBITS-1:0] a_ctl,
  input  logic [IW-1:0]    b_tgt,
  input  logic [NBITS-1:0] b_ctl,
  input  logic [NBITS-1:0] fresh_aux,
  output logic             out_valid,
  output logic [2:0]       out_rule,
  output logic [1:0]       out_count,
  output logic [IW-1:0]    s0_tgt,
  output logic [NBITS-1:0] s0_ctl,
  output logic [IW-1:0]    s1_tgt,
  output logic [NBITS-1:0] s1_ctl,
  output logic [IW-1:0]    s2_tgt,
  output logic [NBITS-1:0] s2_ctl
);
  localparam logic [NBITS-1:0] ONE = NBITS'(1);

  logic             v_q;
  logic [IW-1:0]    t1, t2;
  logic [NBITS-1:0] c1, c2, fr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      t1  <= '0;
      t2  <= '0;
      c1  <= '0;
      c2  <= '0;
      fr  <= '0;
    end else begin
      v_q <= in_valid;
      if (in_valid) begin
        t1 <= a_tgt;
        c1 <= a_ctl;
        t2 <= b_tgt;
        c2 <= b_ctl;
        fr <= fresh_aux;
      end
    end
  end

  logic [NBITS-1:0] m1, m2;
  logic same, t1_in_c2, t2_in_c1, sub_ok, del1, del2;

  assign m1       = ONE << t1;
  assign m2       = ONE << t2;
  assign same     = (t1 == t2) && (c1 == c2);
  assign t1_in_c2 = |(c2 & m1);
  assign t2_in_c1 = |(c1 & m2);
  assign sub_ok   = |(fr & m1) && $onehot(c1);
  assign del1     = |(c1 & fr);
  assign del2     = |(c2 & fr & ~m1);

  always_comb begin
    out_rule  = 3'd0;
    out_count = 2'd2;
    s0_tgt = t1; s0_ctl = c1;
    s1_tgt = t2; s1_ctl = c2;
    s2_tgt = '0; s2_ctl = '0;
    if (same) begin
      out_rule = 3'd1; out_count = 2'd0;
      s0_tgt = '0; s0_ctl = '0;
      s1_tgt = '0; s1_ctl = '0;
    end else if (!t1_in_c2 && !t2_in_c1) begin
      out_rule = 3'd2;
      s0_tgt = t2; s0_ctl = c2;
      s1_tgt = t1; s1_ctl = c1;
    end else if (!t1_in_c2 && t2_in_c1 && (t1 != t2)) begin
      out_rule = 3'd3; out_count = 2'd3;
      s0_tgt = t2; s0_ctl = c2;
      s1_tgt = t1; s1_ctl = c1;
      s2_tgt = t1; s2_ctl = (c1 | c2) & ~m2;
    end else if (t1_in_c2 && !t2_in_c1) begin
      out_rule = 3'd4; out_count = 2'd3;
      s0_tgt = t2; s0_ctl = (c1 | c2) & ~m1;
      s1_tgt = t2; s1_ctl = c2;
      s2_tgt = t1; s2_ctl = c1;
    end else if (sub_ok) begin
      out_rule = 3'd5;
      s1_ctl = (c2 & ~m1) | c1;
    end else if (del1) begin
      out_rule = 3'd6; out_count = 2'd1;
      s0_tgt = t2; s0_ctl = c2;
      s1_tgt = '0; s1_ctl = '0;
    end else if (del2) begin
      out_rule = 3'd7; out_count = 2'd1;
      s1_tgt = '0; s1_ctl = '0;
    end
  end

  assign out_valid = v_q;

  assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_valid_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_cancel_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && a_tgt == b_tgt && a_ctl == b_ctl) |=> (out_count == 2'd0 && out_rule == 3'd1));

  assert_swap_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !(a_tgt == b_tgt && a_ctl == b_ctl) && !b_ctl[a_tgt] && !a_ctl[b_tgt])
    |=> (s0_tgt == $past(b_tgt) && s0_ctl == $past(b_ctl) && s1_tgt == $past(a_tgt) && s1_ctl == $past(a_ctl)));

  assert_dual_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && b_ctl[a_tgt] && !a_ctl[b_tgt]) |=> (out_count == 2'd3 && out_rule == 3'd4));

  assert_delete_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_rule == 3'd6 || out_rule == 3'd7)) |-> (out_count == 2'd1 && s1_ctl == '0 && s2_ctl == '0));
endmodule

// File: tb/gate_pair_rewriter_tb_top.sv
module gate_pair_rewriter_tb_top;
  localparam int N = 8;
  localparam int IW = 3;
  localparam time PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [IW-1:0] a_tgt = '0, b_tgt = '0;
  logic [N-1:0]  a_ctl = '0, b_ctl = '0, fresh_aux = '0;
  logic out_valid;
  logic [2:0] out_rule;
  logic [1:0] out_count;
  logic [IW-1:0] s0_tgt, s1_tgt, s2_tgt;
  logic [N-1:0]  s0_ctl, s1_ctl, s2_ctl;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  gate_pair_rewriter #(.NBITS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .a_tgt(a_tgt), .a_ctl(a_ctl), .b_tgt(b_tgt), .b_ctl(b_ctl), .fresh_aux(fresh_aux),
    .out_valid(out_valid), .out_rule(out_rule), .out_count(out_count),
    .s0_tgt(s0_tgt), .s0_ctl(s0_ctl), .s1_tgt(s1_tgt), .s1_ctl(s1_ctl),
    .s2_tgt(s2_tgt), .s2_ctl(s2_ctl));

  typedef struct {
    logic [2:0] rule; logic [1:0] cnt;
    logic [IW-1:0] t0, t1, t2;
    logic [N-1:0] c0, c1, c2;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t mon_e;

  function automatic exp_t model(input logic [IW-1:0] ta, input logic [N-1:0] ca,
                                 input logic [IW-1:0] tb, input logic [N-1:0] cb,
                                 input logic [N-1:0] fr, input string tag);
    exp_t e;
    logic [N-1:0] ma, mb;
    ma = N'(1) << ta; mb = N'(1) << tb;
    e.tag = tag; e.t0 = '0; e.t1 = '0; e.t2 = '0; e.c0 = '0; e.c1 = '0; e.c2 = '0;
    if (ta == tb && ca == cb) begin e.rule = 1; e.cnt = 0; end
    else if ((cb & ma) == 0 && (ca & mb) == 0) begin
      e.rule = 2; e.cnt = 2; e.t0 = tb; e.c0 = cb; e.t1 = ta; e.c1 = ca;
    end else if ((cb & ma) == 0) begin
      e.rule = 3; e.cnt = 3; e.t0 = tb; e.c0 = cb; e.t1 = ta; e.c1 = ca;
      e.t2 = ta; e.c2 = (ca | cb) & ~mb;
    end else if ((ca & mb) == 0) begin
      e.rule = 4; e.cnt = 3; e.t0 = tb; e.c0 = (ca | cb) & ~ma;
      e.t1 = tb; e.c1 = cb; e.t2 = ta; e.c2 = ca;
    end else if (fr[ta] && $countones(ca) == 1) begin
      e.rule = 5; e.cnt = 2; e.t0 = ta; e.c0 = ca; e.t1 = tb; e.c1 = (cb & ~ma) | ca;
    end else if ((ca & fr) != 0) begin
      e.rule = 6; e.cnt = 1; e.t0 = tb; e.c0 = cb;
    end else if ((cb & fr & ~ma) != 0) begin
      e.rule = 7; e.cnt = 1; e.t0 = ta; e.c0 = ca;
    end else begin
      e.rule = 0; e.cnt = 2; e.t0 = ta; e.c0 = ca; e.t1 = tb; e.c1 = cb;
    end
    return e;
  endfunction

  task automatic send(input logic [IW-1:0] ta, input logic [N-1:0] ca,
                      input logic [IW-1:0] tb, input logic [N-1:0] cb,
                      input logic [N-1:0] fr, input string tag);
    @(negedge clk);
    a_tgt = ta; a_ctl = ca; b_tgt = tb; b_ctl = cb; fresh_aux = fr; in_valid = 1'b1;
    exp_q.push_back(model(ta, ca, tb, cb, fr, tag));
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R1 unexpected out_valid: actual=1 expected=0");
      end else begin
        mon_e = exp_q.pop_front();
        if (out_rule != mon_e.rule || out_count != mon_e.cnt ||
            s0_tgt != mon_e.t0 || s0_ctl != mon_e.c0 || s1_tgt != mon_e.t1 ||
            s1_ctl != mon_e.c1 || s2_tgt != mon_e.t2 || s2_ctl != mon_e.c2) begin
          bad++;
          $display("FAIL %s actual rule=%0d cnt=%0d s=(%0d,%h)(%0d,%h)(%0d,%h) expected rule=%0d cnt=%0d s=(%0d,%h)(%0d,%h)(%0d,%h)",
            mon_e.tag, out_rule, out_count, s0_tgt, s0_ctl, s1_tgt, s1_ctl, s2_tgt, s2_ctl,
            mon_e.rule, mon_e.cnt, mon_e.t0, mon_e.c0, mon_e.t1, mon_e.c1, mon_e.t2, mon_e.c2);
        end
      end
    end
  end

  task automatic check_quiet(input string tag);
    @(negedge clk);
    total++;
    if (out_valid !== 1'b0) begin
      bad++;
      $display("FAIL %s out_valid actual=%b expected=0", tag, out_valid);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (out_valid !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset out_valid actual=%b expected=0", out_valid);
    end
    @(negedge clk) rst_n = 1'b1;
    check_quiet("R1 after reset");

    send(3'd5, 8'h03, 3'd5, 8'h03, 8'h00, "R2 R10 cancel before swap");
    send(3'd1, 8'h0C, 3'd4, 8'h21, 8'h00, "R3 independent swap");
    send(3'd1, 8'h18, 3'd4, 8'h05, 8'h00, "R4 trailing corrective");
    send(3'd2, 8'h21, 3'd6, 8'h84, 8'h00, "R5 leading corrective");
    send(3'd0, 8'h06, 3'd3, 8'h03, 8'h00, "R5 overlapping controls");
    send(3'd7, 8'h02, 3'd1, 8'h81, 8'h80, "R6 substitution");
    send(3'd7, 8'h02, 3'd1, 8'h81, 8'h82, "R6 R10 substitution over deletion");
    send(3'd3, 8'h60, 3'd5, 8'h0A, 8'h40, "R7 delete first");
    send(3'd3, 8'h60, 3'd5, 8'h0A, 8'h02, "R8 delete second");
    send(3'd3, 8'h60, 3'd5, 8'h0A, 8'h08, "R8 R9 fresh only on t1");
    send(3'd3, 8'h60, 3'd5, 8'h0A, 8'h00, "R9 no rule");
    idle();
    check_quiet("R1 idle gap");
    send(3'd6, 8'h00, 3'd6, 8'h00, 8'hFF, "R2 empty-mask cancel");
    send(3'd2, 8'h00, 3'd5, 8'h04, 8'h00, "R5 inversion first");
    idle();
    check_quiet("R1 final idle");
    repeat (2) @(negedge clk);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R1 missing results actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule